// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block keeps the time of day and the calendar in binary-coded decimal. It counts one-second ticks supplied by logic outside it. The fields are seconds, minutes, hours, day of month, month, two-digit year and a free-running day-of-week index. The hour field holds either a 24-hour count or a 12-hour count with a PM flag, and a mode bit inside that field selects between them. February gets a 29th day in every year whose two-digit value is a multiple of four. No correction is made at century boundaries.

Software or a bus front end sets the time by presenting all fields on the load inputs and pulsing `load` for one cycle. Every field is available at all times on registered outputs. The block holds its state between ticks. Each tick is a single-cycle pulse, and it may carry a rollover through every field at once, from seconds up to the year.

Top module: `bcd_rtc_core`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. Each tick advances seconds. When seconds wrap from 59 to 00, minutes advance. When minutes wrap, the hour advances.
- R2: With hour bit 7 set (24-hour mode), bits 5:0 count in BCD from 00 to 23. The step from 23 to 00 advances the day.
- R3: With hour bit 7 clear (12-hour mode), bits 4:0 count in BCD from 01 to 12, and bit 5 is the PM flag (1 = PM). The step from 11 to 12 inverts the PM flag, and the step from 12 to 01 leaves it unchanged. The day advances only on the step from 11 PM to 12 AM.
- R4: While `rst` is high, the outputs take the following values on the clock edge: seconds 00, minutes 00, hour 8'h12 (12-hour mode, AM, 12), date 01, month 01, year 00, day of week 0.
- R5: The 3-bit day of week advances by one on each day rollover and follows the order 0,1,2,3,4,5,6,0.
- R6: The date counts from 01. Months 04, 06, 09 and 11 end after day 30. Months 01, 03, 05, 07, 08, 10 and 12 end after day 31. When a month ends, the date returns to 01 and the month advances.
- R7: Month 02 ends after day 29 when the year value is divisible by four, and after day 28 otherwise. The year 00 counts as a leap year.
- R8: The month steps from 12 to 01 and advances the year. The year steps from 99 to 00.
- R9: When `load` is high, every field takes its load input on that edge, and this takes priority over a tick in the same cycle. The next tick counts on from the loaded value.
- R10: With neither `tick` nor `load` high, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance pulse |
| load | input | 1 | Parallel load strobe |
| ld_sec | input | 8 | Seconds to load, BCD |
| ld_min | input | 8 | Minutes to load, BCD |
| ld_hour | input | 8 | Hour to load: bit 7 mode, bit 5 PM or tens, BCD digits |
| ld_date | input | 8 | Day of month to load, BCD |
| ld_month | input | 8 | Month to load, BCD |
| ld_year | input | 8 | Two-digit year to load, BCD |
| ld_dow | input | 3 | Day of week to load |
| sec | output | 8 | Seconds, BCD |
| min | output | 8 | Minutes, BCD |
| hour | output | 8 | Hour with mode and PM bits |
| date | output | 8 | Day of month, BCD |
| month | output | 8 | Month, BCD |
| year | output | 8 | Year, BCD |
| dow | output | 3 | Day of week, 0 to 6 |

## Verification
The bench builds the block with its default parameters: a seven-day week and a leap period of four years. Because the full 8-bit state can be loaded in one cycle, any rollover can be reached with a load followed by a single tick, and the bench needs no long runs of counting. That lets it reach leap years 00 and 12, the non-leap years 10 and 23, both PM transitions, and the full year wrap at 99.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int HOUR_MODE_BIT = 7;
  localparam int HOUR_PM_BIT   = 5;

  // Advance a two-digit BCD value by one, carrying ones into tens.
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic int unsigned bcd_to_bin(input logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction
endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic         en,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  import rtc_pkg::*;

  always_comb begin
    nxt  = cur;
    wrap = 1'b0;
    if (en) begin
      if (cur >= hi) begin
        nxt  = lo;
        wrap = 1'b1;
      end else begin
        nxt = bcd_inc(cur);
      end
    end
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic         en,
  output logic [W-1:0] nxt,
  output logic         day_wrap
);
  import rtc_pkg::*;

  logic       mode24;
  logic       pm;
  logic [7:0] h24;
  logic [7:0] h12;

  assign mode24 = cur[HOUR_MODE_BIT];
  assign pm     = cur[HOUR_PM_BIT];
  assign h24    = {2'b00, cur[5:0]};
  assign h12    = {3'b000, cur[4:0]};

  always_comb begin
    nxt      = cur;
    day_wrap = 1'b0;
    if (en) begin
      if (mode24) begin
        if (h24 >= 8'h23) begin
          nxt      = {cur[7:6], 6'h00};
          day_wrap = 1'b1;
        end else begin
          nxt = {cur[7:6], 6'(bcd_inc(h24))};
        end
      end else begin
        if (h12 >= 8'h12) begin
          nxt = {cur[7:6], pm, 5'h01};
        end else if (h12 == 8'h11) begin
          nxt      = {cur[7:6], ~pm, 5'h12};
          day_wrap = pm;
        end else begin
          nxt = {cur[7:6], pm, 5'(bcd_inc(h12))};
        end
      end
    end
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len #(
  parameter int LEAP_PERIOD = 4
) (
  input  logic [7:0] month,
  input  logic [7:0] year,
  output logic [7:0] last_day
);
  import rtc_pkg::*;

  logic leap;
  assign leap = (bcd_to_bin(year) % LEAP_PERIOD) == 0;

  always_comb begin
    unique case (month)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int         DOW_DAYS    = 7,
  parameter int         LEAP_PERIOD = 4,
  parameter logic [7:0] SM_LAST     = 8'h59,
  parameter logic [7:0] MONTH_LAST  = 8'h12,
  parameter logic [7:0] YEAR_LAST   = 8'h99
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] ld_sec,
  input  logic [7:0] ld_min,
  input  logic [7:0] ld_hour,
  input  logic [7:0] ld_date,
  input  logic [7:0] ld_month,
  input  logic [7:0] ld_year,
  input  logic [2:0] ld_dow,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] date,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic [2:0] dow
);
  localparam int          SM_STAGES = 2;
  localparam logic [2:0]  DOW_MAX   = 3'(DOW_DAYS - 1);

  // Seconds and minutes share one structure; chained via generate.
  logic [SM_STAGES-1:0][7:0] sm_cur;
  logic [SM_STAGES-1:0][7:0] sm_nxt;
  logic [SM_STAGES:0]        sm_en;

  assign sm_cur[0] = sec;
  assign sm_cur[1] = min;
  assign sm_en[0]  = tick;

  for (genvar gi = 0; gi < SM_STAGES; gi++) begin : g_sm
    logic w;
    rtc_bcd_step #(.W(8)) u_step (
      .cur (sm_cur[gi]),
      .en  (sm_en[gi]),
      .lo  (8'h00),
      .hi  (SM_LAST),
      .nxt (sm_nxt[gi]),
      .wrap(w)
    );
    assign sm_en[gi+1] = w;
  end

  logic [7:0] hour_nxt;
  logic       day_en;
  rtc_hour_step #(.W(8)) u_hour (
    .cur     (hour),
    .en      (sm_en[SM_STAGES]),
    .nxt     (hour_nxt),
    .day_wrap(day_en)
  );

  logic [7:0] last_day;
  rtc_month_len #(.LEAP_PERIOD(LEAP_PERIOD)) u_mlen (
    .month   (month),
    .year    (year),
    .last_day(last_day)
  );

  logic [7:0] date_nxt, month_nxt, year_nxt;
  logic       month_en, year_en, year_wrap;

  rtc_bcd_step #(.W(8)) u_date (
    .cur(date), .en(day_en), .lo(8'h01), .hi(last_day),
    .nxt(date_nxt), .wrap(month_en)
  );
  rtc_bcd_step #(.W(8)) u_month (
    .cur(month), .en(month_en), .lo(8'h01), .hi(MONTH_LAST),
    .nxt(month_nxt), .wrap(year_en)
  );
  rtc_bcd_step #(.W(8)) u_year (
    .cur(year), .en(year_en), .lo(8'h00), .hi(YEAR_LAST),
    .nxt(year_nxt), .wrap(year_wrap)
  );

  logic [2:0] dow_nxt;
  always_comb begin
    dow_nxt = dow;
    if (day_en) dow_nxt = (dow >= DOW_MAX) ? 3'd0 : dow + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec   <= 8'h00;
      min   <= 8'h00;
      hour  <= 8'h12;
      date  <= 8'h01;
      month <= 8'h01;
      year  <= 8'h00;
      dow   <= 3'd0;
    end else if (load) begin
      sec   <= ld_sec;
      min   <= ld_min;
      hour  <= ld_hour;
      date  <= ld_date;
      month <= ld_month;
      year  <= ld_year;
      dow   <= ld_dow;
    end else if (tick) begin
      sec   <= sm_nxt[0];
      min   <= sm_nxt[1];
      hour  <= hour_nxt;
      date  <= date_nxt;
      month <= month_nxt;
      year  <= year_nxt;
      dow   <= dow_nxt;
    end
  end

  logic unused_ok;
  assign unused_ok = year_wrap;
endmodule

// File: rtl/rtc_core_checker.sv
module rtc_core_checker (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       load,
  input logic [7:0] ld_sec,
  input logic [7:0] ld_min,
  input logic [7:0] ld_hour,
  input logic [7:0] ld_date,
  input logic [7:0] ld_month,
  input logic [7:0] ld_year,
  input logic [2:0] ld_dow,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] date,
  input logic [7:0] month,
  input logic [7:0] year,
  input logic [2:0] dow
);
  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && sec == 8'h59) |=> (sec == 8'h00 && min != $past(min)));

  p_h24_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && hour[7] && hour[5:0] == 6'h23 && min == 8'h59 && sec == 8'h59)
    |=> (hour[5:0] == 6'h00 && hour[7]));

  p_pm_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && !hour[7] && hour[4:0] == 5'h11 && min == 8'h59 && sec == 8'h59)
    |=> (hour[5] != $past(hour[5]) && hour[4:0] == 5'h12));

  p_reset_r4: assert property (@(posedge clk)
    rst |=> (sec == 8'h00 && hour == 8'h12 && date == 8'h01 && dow == 3'd0));

  p_dow_order_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !load) |=> (dow == $past(dow) ||
                         dow == (($past(dow) >= 3'd6) ? 3'd0 : $past(dow) + 3'd1)));

  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> (sec == $past(ld_sec) && hour == $past(ld_hour) &&
              year == $past(ld_year) && dow == $past(ld_dow)));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> ($stable(sec) && $stable(min) && $stable(hour) &&
                          $stable(date) && $stable(month) && $stable(year) && $stable(dow)));
endmodule

bind bcd_rtc_core rtc_core_checker u_chk (.*);

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;
  logic clk = 1'b0;
  logic rst, tick, load;
  logic [7:0] ld_sec, ld_min, ld_hour, ld_date, ld_month, ld_year;
  logic [2:0] ld_dow;
  logic [7:0] sec, min, hour, date, month, year;
  logic [2:0] dow;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  bcd_rtc_core u_dut (
    .clk(clk), .rst(rst), .tick(tick), .load(load),
    .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_date(ld_date),
    .ld_month(ld_month), .ld_year(ld_year), .ld_dow(ld_dow),
    .sec(sec), .min(min), .hour(hour), .date(date),
    .month(month), .year(year), .dow(dow)
  );

  // Vector: {req, load state, expected state after one tick}.
  // State packing: {sec, min, hour, date, month, year, dow} = 51 bits.
  localparam int NV = 23;
  localparam logic [105:0] VEC [NV] = '{
    {4'd1,  8'h05,8'h10,8'h03,8'h15,8'h06,8'h24,3'd2, 8'h06,8'h10,8'h03,8'h15,8'h06,8'h24,3'd2},
    {4'd1,  8'h59,8'h10,8'h03,8'h15,8'h06,8'h24,3'd2, 8'h00,8'h11,8'h03,8'h15,8'h06,8'h24,3'd2},
    {4'd1,  8'h59,8'h59,8'h03,8'h15,8'h06,8'h24,3'd2, 8'h00,8'h00,8'h04,8'h15,8'h06,8'h24,3'd2},
    {4'd2,  8'h59,8'h59,8'h89,8'h15,8'h06,8'h24,3'd2, 8'h00,8'h00,8'h90,8'h15,8'h06,8'h24,3'd2},
    {4'd2,  8'h59,8'h59,8'h99,8'h15,8'h06,8'h24,3'd2, 8'h00,8'h00,8'hA0,8'h15,8'h06,8'h24,3'd2},
    {4'd2,  8'h59,8'h59,8'hA3,8'h15,8'h06,8'h24,3'd2, 8'h00,8'h00,8'h80,8'h16,8'h06,8'h24,3'd3},
    {4'd3,  8'h59,8'h59,8'h11,8'h15,8'h06,8'h24,3'd2, 8'h00,8'h00,8'h32,8'h15,8'h06,8'h24,3'd2},
    {4'd3,  8'h59,8'h59,8'h32,8'h15,8'h06,8'h24,3'd2, 8'h00,8'h00,8'h21,8'h15,8'h06,8'h24,3'd2},
    {4'd3,  8'h59,8'h59,8'h12,8'h15,8'h06,8'h24,3'd2, 8'h00,8'h00,8'h01,8'h15,8'h06,8'h24,3'd2},
    {4'd3,  8'h59,8'h59,8'h31,8'h15,8'h06,8'h24,3'd2, 8'h00,8'h00,8'h12,8'h16,8'h06,8'h24,3'd3},
    {4'd6,  8'h59,8'h59,8'h31,8'h30,8'h04,8'h24,3'd2, 8'h00,8'h00,8'h12,8'h01,8'h05,8'h24,3'd3},
    {4'd6,  8'h59,8'h59,8'h31,8'h30,8'h05,8'h24,3'd2, 8'h00,8'h00,8'h12,8'h31,8'h05,8'h24,3'd3},
    {4'd6,  8'h59,8'h59,8'h31,8'h30,8'h11,8'h24,3'd2, 8'h00,8'h00,8'h12,8'h01,8'h12,8'h24,3'd3},
    {4'd6,  8'h59,8'h59,8'h31,8'h31,8'h01,8'h24,3'd2, 8'h00,8'h00,8'h12,8'h01,8'h02,8'h24,3'd3},
    {4'd7,  8'h59,8'h59,8'h31,8'h28,8'h02,8'h24,3'd2, 8'h00,8'h00,8'h12,8'h29,8'h02,8'h24,3'd3},
    {4'd7,  8'h59,8'h59,8'h31,8'h28,8'h02,8'h23,3'd2, 8'h00,8'h00,8'h12,8'h01,8'h03,8'h23,3'd3},
    {4'd7,  8'h59,8'h59,8'h31,8'h29,8'h02,8'h24,3'd2, 8'h00,8'h00,8'h12,8'h01,8'h03,8'h24,3'd3},
    {4'd7,  8'h59,8'h59,8'h31,8'h28,8'h02,8'h00,3'd2, 8'h00,8'h00,8'h12,8'h29,8'h02,8'h00,3'd3},
    {4'd7,  8'h59,8'h59,8'h31,8'h28,8'h02,8'h10,3'd2, 8'h00,8'h00,8'h12,8'h01,8'h03,8'h10,3'd3},
    {4'd7,  8'h59,8'h59,8'h31,8'h28,8'h02,8'h12,3'd2, 8'h00,8'h00,8'h12,8'h29,8'h02,8'h12,3'd3},
    {4'd8,  8'h59,8'h59,8'h31,8'h31,8'h12,8'h24,3'd2, 8'h00,8'h00,8'h12,8'h01,8'h01,8'h25,3'd3},
    {4'd8,  8'h59,8'h59,8'h31,8'h31,8'h12,8'h99,3'd2, 8'h00,8'h00,8'h12,8'h01,8'h01,8'h00,3'd3},
    {4'd5,  8'h59,8'h59,8'h31,8'h15,8'h06,8'h24,3'd6, 8'h00,8'h00,8'h12,8'h16,8'h06,8'h24,3'd0}
  };

  function automatic string tag(input int r);
    case (r)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  function automatic logic [50:0] state();
    return {sec, min, hour, date, month, year, dow};
  endfunction

  task automatic check(input string t, input logic [50:0] exp);
    n_checks++;
    if (state() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", t, state(), exp);
    end
  endtask

  task automatic do_load(input logic [50:0] s, input logic with_tick);
    @(negedge clk);
    {ld_sec, ld_min, ld_hour, ld_date, ld_month, ld_year, ld_dow} = s;
    load = 1'b1;
    tick = with_tick;
    @(negedge clk);
    load = 1'b0;
    tick = 1'b0;
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick = 1'b0; load = 1'b0;
    {ld_sec, ld_min, ld_hour, ld_date, ld_month, ld_year, ld_dow} = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R4 reset state
    check("R4", {8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, 3'd0});

    // R10: idle cycles keep everything
    repeat (5) @(negedge clk);
    check("R10", {8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, 3'd0});

    // Vector table: load, confirm load (R9), one tick, compare
    for (int i = 0; i < NV; i++) begin
      do_load(VEC[i][101:51], 1'b0);
      check("R9", VEC[i][101:51]);
      do_tick();
      check(tag(int'(VEC[i][105:102])), VEC[i][50:0]);
    end

    // R9: load wins over a tick in the same cycle, then counting resumes
    do_load({8'h30, 8'h20, 8'h07, 8'h10, 8'h03, 8'h41, 3'd4}, 1'b1);
    check("R9", {8'h30, 8'h20, 8'h07, 8'h10, 8'h03, 8'h41, 3'd4});
    do_tick();
    check("R9", {8'h31, 8'h20, 8'h07, 8'h10, 8'h03, 8'h41, 3'd4});

    // R10: idle after activity
    repeat (4) @(negedge clk);
    check("R10", {8'h31, 8'h20, 8'h07, 8'h10, 8'h03, 8'h41, 3'd4});

    // R1: run of ten ticks across a minute boundary
    do_load({8'h55, 8'h08, 8'h07, 8'h10, 8'h03, 8'h41, 3'd4}, 1'b0);
    for (int k = 0; k < 10; k++) do_tick();
    check("R1", {8'h05, 8'h09, 8'h07, 8'h10, 8'h03, 8'h41, 3'd4});

    // R4: reset in the middle of operation
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R4", {8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, 3'd0});

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule